// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Command Controller

This block is the digital control core of a two-channel potentiometer whose settings survive power cycles. A host shifts 24-bit command frames into it over a three-wire serial port: a serial clock, a data input and an active-low select. All three are sampled by the block's own system clock. Nothing is decoded while the select is low. When the select returns high, the last 24 bits shifted in are taken as one frame and executed. Each channel holds a volatile wiper code, which drives the resistor network, and a nonvolatile backup code. The backup codes are modelled as plain registers, and a store into one of them occupies the block for a fixed number of cycles.

The serial output always shows the bit that entered 24 serial clocks earlier, so several devices can be chained on one select line. After a read command, the next frame shifts the requested register out in place of that pass-through data. A write-protect input freezes both register sets. A preset input copies the backup codes into the wipers whatever the protect state is.

A controller with three named states sequences each frame. `ST_IDLE` waits for the select to rise (transition *frame_end*, which goes to `ST_EXEC`). `ST_EXEC` decodes and acts in one cycle and then returns to `ST_IDLE` (*exec_done*), or goes to `ST_BUSY` when a backup store is executed (*store_start*). `ST_BUSY` counts down and returns to `ST_IDLE` when the count reaches zero (*store_done*). Frames that end in `ST_BUSY` are dropped.

Top module: `pot_serial_ctrl`

## Requirements
- R1: After reset both wiper codes and both backup codes are 0x200 (midscale of the 10-bit code), `ready` is 1 and `sdo` is 0.
- R2: `sdi` is captured on each rising `sclk` while `cs_n` is low, most significant bit first. The frame is the last 24 bits captured: command in bits 23:20, channel address in bits 19:16, data in bits 15:0. The code used is data bits 9:0.
- R3: `sdo` equals the `sdi` bit captured 24 rising `sclk` edges earlier, including across frames, so that the first 24 bits of a 48-bit transfer reappear during its second 24 bits.
- R4: A frame takes effect only after `cs_n` rises. Bits shifted while `cs_n` is held low change no output except `sdo`.
- R5: Command 0xB loads the code into the wiper of channel 0 (address 0x0) or channel 1 (address 0x1). Any other address changes nothing.
- R6: Command 0x2 copies the addressed wiper into its backup code. Command 0x3 writes the code into the addressed backup code. Each of these holds `ready` low for exactly BUSY_CYCLES clock cycles, starting two clocks after `cs_n` rises.
- R7: Command 0x1 reloads the addressed wiper from its backup code. Command 0x8 reloads both wipers from their backup codes.
- R8: Command 0xA (wiper) and command 0x9 (backup) to a valid address load the shift register. The next 24 `sclk` edges then shift out {command, address, data bits 15:10 of the request, 10-bit register value}.
- R9: While `wp_n` is 0, commands 0x1, 0x2, 0x3, 0x8 and 0xB change no register and do not lower `ready`. Read commands still work.
- R10: A rising edge of `preset` copies both backup codes into the wipers, also while `wp_n` is 0. It takes priority over a command write in the same cycle.
- R11: A frame whose `cs_n` rise arrives while `ready` is 0 is discarded.
- R12: Command codes other than 0x1, 0x2, 0x3, 0x8, 0x9, 0xA and 0xB change no register and leave `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, oversampled by clk |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| wp_n | input | 1 | Active-low write protect |
| preset | input | 1 | Rising edge reloads wipers from backup codes |
| sdo | output | 1 | Daisy-chain and readback serial output |
| ready | output | 1 | Low while a backup store is in progress |
| wiper_codes | output | NCH*CODE_W | Wiper codes, channel 0 in the low bits |

## Verification
A wrong internal state surfaces at the ports in one of three ways. A corrupted wiper shows on `wiper_codes` within three clocks of the `cs_n` rise. A corrupted backup code stays hidden until a reload, a preset or a backup readback brings it out, so every backup write is followed by one of these. A stuck busy counter shows as a `ready` low window of the wrong length, or as a frame that is silently dropped. The bench therefore measures that window cycle by cycle and sends a frame inside it.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int FRAME_W = 24;
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 16;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP      = 4'h0,
        CMD_LOAD_ONE = 4'h1,
        CMD_STORE_W  = 4'h2,
        CMD_STORE_D  = 4'h3,
        CMD_LOAD_ALL = 4'h8,
        CMD_READ_NV  = 4'h9,
        CMD_READ_WP  = 4'hA,
        CMD_SET_WP   = 4'hB
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_BUSY = 2'd2
    } state_e;
endpackage

// File: rtl/pot_shifter.sv
module pot_shifter #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdi,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    output logic [FRAME_W-1:0] frame,
    output logic               sdo
);
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_en) begin
            shreg <= load_word;
        end else if (shift_en) begin
            shreg <= {shreg[FRAME_W-2:0], sdi};
        end
    end

    assign frame = shreg;
    assign sdo   = shreg[FRAME_W-1];
endmodule

// File: rtl/pot_regs.sv
module pot_regs #(
    parameter int NCH    = 2,
    parameter int CODE_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  preset_pulse,
    input  logic [NCH-1:0]        wr_wiper,
    input  logic [NCH-1:0]        ld_from_nv,
    input  logic [NCH-1:0]        wr_nv,
    input  logic                  nv_from_wiper,
    input  logic [CODE_W-1:0]     code_in,
    output logic [NCH*CODE_W-1:0] wiper_o,
    output logic [NCH*CODE_W-1:0] nv_o
);
    localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [CODE_W-1:0] wiper_q;
        logic [CODE_W-1:0] nv_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wiper_q <= MIDSCALE;
                nv_q    <= MIDSCALE;
            end else begin
                if (wr_nv[ch]) begin
                    nv_q <= nv_from_wiper ? wiper_q : code_in;
                end
                if (preset_pulse || ld_from_nv[ch]) begin
                    wiper_q <= nv_q;
                end else if (wr_wiper[ch]) begin
                    wiper_q <= code_in;
                end
            end
        end

        assign wiper_o[ch*CODE_W +: CODE_W] = wiper_q;
        assign nv_o[ch*CODE_W +: CODE_W]    = nv_q;
    end
endmodule

// File: rtl/pot_ctrl.sv
module pot_ctrl
    import pot_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CODE_W      = 10,
    parameter int BUSY_CYCLES = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_rise,
    input  logic                  wp_n,
    input  logic [FRAME_W-1:0]    frame,
    input  logic [NCH*CODE_W-1:0] wiper_all,
    input  logic [NCH*CODE_W-1:0] nv_all,
    output logic [NCH-1:0]        wr_wiper,
    output logic [NCH-1:0]        ld_from_nv,
    output logic [NCH-1:0]        wr_nv,
    output logic                  nv_from_wiper,
    output logic [CODE_W-1:0]     code_out,
    output logic                  load_en,
    output logic [FRAME_W-1:0]    load_word,
    output logic                  ready
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam int CH_W  = $clog2(NCH);
    localparam int PAD_W = DATA_W - CODE_W;

    state_e             state, state_n;
    logic [FRAME_W-1:0] frame_q, frame_n;
    logic [CNT_W-1:0]   cnt, cnt_n;

    cmd_e               cmd;
    logic [ADDR_W-1:0]  addr;
    logic [PAD_W-1:0]   echo;
    logic [CH_W-1:0]    idx;
    logic               addr_ok;
    logic               allowed;
    logic [NCH-1:0]     sel;

    assign cmd      = cmd_e'(frame_q[FRAME_W-1 -: CMD_W]);
    assign addr     = frame_q[DATA_W +: ADDR_W];
    assign echo     = frame_q[CODE_W +: PAD_W];
    assign code_out = frame_q[CODE_W-1:0];
    assign idx      = addr[CH_W-1:0];
    assign addr_ok  = (32'(addr) < NCH);
    assign allowed  = wp_n;

    always_comb begin
        sel = '0;
        if (addr_ok) sel[idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            frame_q <= '0;
            cnt     <= '0;
        end else begin
            state   <= state_n;
            frame_q <= frame_n;
            cnt     <= cnt_n;
        end
    end

    always_comb begin
        state_n       = state;
        frame_n       = frame_q;
        cnt_n         = cnt;
        wr_wiper      = '0;
        ld_from_nv    = '0;
        wr_nv         = '0;
        nv_from_wiper = 1'b0;
        load_en       = 1'b0;
        load_word     = '0;
        unique case (state)
            ST_IDLE: begin
                if (cs_rise) begin
                    frame_n = frame;
                    state_n = ST_EXEC;
                end
            end
            ST_EXEC: begin
                state_n = ST_IDLE;
                unique case (cmd)
                    CMD_SET_WP:   if (allowed) wr_wiper = sel;
                    CMD_LOAD_ONE: if (allowed) ld_from_nv = sel;
                    CMD_LOAD_ALL: if (allowed) ld_from_nv = '1;
                    CMD_STORE_W, CMD_STORE_D: begin
                        if (allowed && addr_ok) begin
                            wr_nv         = sel;
                            nv_from_wiper = (cmd == CMD_STORE_W);
                            cnt_n         = CNT_W'(BUSY_CYCLES - 1);
                            state_n       = ST_BUSY;
                        end
                    end
                    CMD_READ_NV, CMD_READ_WP: begin
                        if (addr_ok) begin
                            load_en   = 1'b1;
                            load_word = {cmd, addr, echo,
                                         (cmd == CMD_READ_NV) ? nv_all[idx*CODE_W +: CODE_W]
                                                              : wiper_all[idx*CODE_W +: CODE_W]};
                        end
                    end
                    default: ;
                endcase
            end
            ST_BUSY: begin
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n = cnt - 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign ready = (state != ST_BUSY);
endmodule

// File: rtl/pot_serial_ctrl.sv
module pot_serial_ctrl
    import pot_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CODE_W      = 10,
    parameter int BUSY_CYCLES = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  sdi,
    input  logic                  cs_n,
    input  logic                  wp_n,
    input  logic                  preset,
    output logic                  sdo,
    output logic                  ready,
    output logic [NCH*CODE_W-1:0] wiper_codes
);
    logic sclk_q, cs_q, preset_q;
    logic sclk_rise, cs_rise, preset_pulse;

    logic [FRAME_W-1:0]    frame, load_word;
    logic                  load_en;
    logic [NCH-1:0]        wr_wiper, ld_from_nv, wr_nv;
    logic                  nv_from_wiper;
    logic [CODE_W-1:0]     code;
    logic [NCH*CODE_W-1:0] nv_codes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            preset_q <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            cs_q     <= cs_n;
            preset_q <= preset;
        end
    end

    assign sclk_rise    = sclk & ~sclk_q;
    assign cs_rise      = cs_n & ~cs_q;
    assign preset_pulse = preset & ~preset_q;

    pot_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (sclk_rise & ~cs_n),
        .sdi       (sdi),
        .load_en   (load_en),
        .load_word (load_word),
        .frame     (frame),
        .sdo       (sdo)
    );

    pot_ctrl #(.NCH(NCH), .CODE_W(CODE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_rise       (cs_rise),
        .wp_n          (wp_n),
        .frame         (frame),
        .wiper_all     (wiper_codes),
        .nv_all        (nv_codes),
        .wr_wiper      (wr_wiper),
        .ld_from_nv    (ld_from_nv),
        .wr_nv         (wr_nv),
        .nv_from_wiper (nv_from_wiper),
        .code_out      (code),
        .load_en       (load_en),
        .load_word     (load_word),
        .ready         (ready)
    );

    pot_regs #(.NCH(NCH), .CODE_W(CODE_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .preset_pulse  (preset_pulse),
        .wr_wiper      (wr_wiper),
        .ld_from_nv    (ld_from_nv),
        .wr_nv         (wr_nv),
        .nv_from_wiper (nv_from_wiper),
        .code_in       (code),
        .wiper_o       (wiper_codes),
        .nv_o          (nv_codes)
    );
endmodule

// File: rtl/pot_serial_ctrl_chk.sv
module pot_serial_ctrl_chk #(
    parameter int NCH         = 2,
    parameter int CODE_W      = 10,
    parameter int BUSY_CYCLES = 200
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wp_n,
    input logic                  preset,
    input logic                  ready,
    input logic [NCH*CODE_W-1:0] wiper_codes,
    input logic [NCH*CODE_W-1:0] nv_codes
);
    logic [31:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_run <= '0;
        else if (ready) low_run <= '0;
        else            low_run <= low_run + 1;
    end

    // R10: a preset edge loads the backup codes into the wipers
    p_preset_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preset) |=> (wiper_codes == $past(nv_codes)));

    // R9: protect low freezes the backup codes
    p_wp_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> $stable(nv_codes));

    // R11: during a store no frame changes the wipers
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !preset) |=> $stable(wiper_codes));

    // R6: the busy window never exceeds its length
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (low_run < BUSY_CYCLES));
endmodule

bind pot_serial_ctrl pot_serial_ctrl_chk #(
    .NCH(NCH), .CODE_W(CODE_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_n        (wp_n),
    .preset      (preset),
    .ready       (ready),
    .wiper_codes (wiper_codes),
    .nv_codes    (nv_codes)
);

// File: tb/tb_pot_serial_ctrl.sv
module tb_pot_serial_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, wp_n = 1'b1, preset = 1'b0;
    logic sdo, ready;
    logic [19:0] wiper_codes;

    int checks = 0, errors = 0;
    logic [9:0] mw [2];
    logic [9:0] mn [2];
    logic [23:0] cap, cap2;

    always #(CLK_PERIOD/2) clk = ~clk;

    pot_serial_ctrl #(.NCH(2), .CODE_W(10), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .wp_n(wp_n), .preset(preset), .sdo(sdo), .ready(ready),
        .wiper_codes(wiper_codes));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] fw(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
        return {c, a, d};
    endfunction

    task automatic check_wipers(input string req);
        check(wiper_codes[9:0] == mw[0], req, 32'(wiper_codes[9:0]), 32'(mw[0]));
        check(wiper_codes[19:10] == mw[1], req, 32'(wiper_codes[19:10]), 32'(mw[1]));
    endtask

    task automatic shift24(input logic [23:0] w, output logic [23:0] c);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk); sdi = w[i]; sclk = 1'b0;
            @(negedge clk); c[i] = sdo; sclk = 1'b1;
            @(negedge clk);
        end
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic send(input logic [23:0] w, input int settle, output logic [23:0] c);
        @(negedge clk); cs_n = 1'b0;
        shift24(w, c);
        @(negedge clk); cs_n = 1'b1;
        repeat (settle) @(negedge clk);
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 10 * BUSY) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        check_wipers("R1");
        check(ready == 1'b1, "R1 ready", 32'(ready), 1);
        check(sdo == 1'b0, "R1 sdo", 32'(sdo), 0);
    endtask

    task automatic t_write();
        send(fw(4'hB, 4'h0, 16'h0155), 4, cap); mw[0] = 10'h155;
        check_wipers("R5 R2 ch0 write");
        send(fw(4'hB, 4'h1, 16'h03FF), 4, cap); mw[1] = 10'h3FF;
        check_wipers("R5 ch1 write");
        send(fw(4'hB, 4'h3, 16'h0001), 4, cap);
        check_wipers("R5 bad address");
    endtask

    task automatic t_deferred();
        @(negedge clk); cs_n = 1'b0;
        shift24(fw(4'hB, 4'h0, 16'h00F0), cap);
        repeat (10) @(negedge clk);
        check_wipers("R4 held while cs low");
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        mw[0] = 10'h0F0;
        check_wipers("R4 after cs rise");
    endtask

    task automatic t_store();
        int low = 0;
        send(fw(4'h2, 4'h0, 16'h0000), 0, cap); mn[0] = mw[0];
        repeat (3 * BUSY) begin
            @(negedge clk);
            if (!ready) low++;
        end
        check(low == BUSY, "R6 busy length", 32'(low), 32'(BUSY));
        send(fw(4'hB, 4'h0, 16'h0011), 4, cap); mw[0] = 10'h011;
        send(fw(4'h1, 4'h0, 16'h0000), 4, cap); mw[0] = mn[0];
        check_wipers("R7 R6 reload ch0");
        send(fw(4'h3, 4'h1, 16'h0123), 3, cap); mn[1] = 10'h123;
        check(ready == 1'b0, "R6 store data busy", 32'(ready), 0);
        wait_ready();
        check_wipers("R6 wiper untouched by store");
        send(fw(4'h8, 4'h0, 16'h0000), 4, cap); mw[0] = mn[0]; mw[1] = mn[1];
        check_wipers("R7 reload all");
    endtask

    task automatic t_busy_ignore();
        send(fw(4'h3, 4'h0, 16'h0050), 0, cap); mn[0] = 10'h050;
        send(fw(4'hB, 4'h0, 16'h03AA), 2, cap);
        check(ready == 1'b0, "R11 frame inside busy", 32'(ready), 0);
        wait_ready();
        repeat (4) @(negedge clk);
        check_wipers("R11 dropped frame");
        send(fw(4'h1, 4'h0, 16'h0000), 4, cap); mw[0] = mn[0];
        check_wipers("R11 R7 store committed");
    endtask

    task automatic t_readback();
        send(fw(4'hA, 4'h1, 16'h0000), 4, cap);
        send(fw(4'h0, 4'h0, 16'h0000), 4, cap);
        check(cap == {4'hA, 4'h1, 6'h0, mw[1]}, "R8 wiper readback", 32'(cap), 32'({4'hA, 4'h1, 6'h0, mw[1]}));
        send(fw(4'h9, 4'h0, 16'h0000), 4, cap);
        send(fw(4'h0, 4'h0, 16'h0000), 4, cap);
        check(cap == {4'h9, 4'h0, 6'h0, mn[0]}, "R8 backup readback", 32'(cap), 32'({4'h9, 4'h0, 6'h0, mn[0]}));
    endtask

    task automatic t_unknown();
        send(fw(4'hF, 4'h0, 16'h00FF), 3, cap);
        check(ready == 1'b1, "R12 ready", 32'(ready), 1);
        check_wipers("R12 no change");
    endtask

    task automatic t_daisy();
        @(negedge clk); cs_n = 1'b0;
        shift24(fw(4'hB, 4'h0, 16'h03FF), cap);
        shift24(fw(4'hB, 4'h1, 16'h00AA), cap2);
        @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(cap == fw(4'hF, 4'h0, 16'h00FF), "R3 previous frame out", 32'(cap), 32'(fw(4'hF, 4'h0, 16'h00FF)));
        check(cap2 == fw(4'hB, 4'h0, 16'h03FF), "R3 first word passes", 32'(cap2), 32'(fw(4'hB, 4'h0, 16'h03FF)));
        mw[1] = 10'h0AA;
        check_wipers("R2 last 24 bits executed");
    endtask

    task automatic t_protect();
        send(fw(4'hB, 4'h0, 16'h0111), 4, cap); mw[0] = 10'h111;
        @(negedge clk); wp_n = 1'b0;
        send(fw(4'hB, 4'h0, 16'h0001), 4, cap);
        check_wipers("R9 wiper write blocked");
        send(fw(4'h3, 4'h1, 16'h0005), 3, cap);
        check(ready == 1'b1, "R9 no busy", 32'(ready), 1);
        send(fw(4'h1, 4'h0, 16'h0000), 4, cap);
        check_wipers("R9 reload blocked");
        send(fw(4'h9, 4'h1, 16'h0000), 4, cap);
        send(fw(4'h0, 4'h0, 16'h0000), 4, cap);
        check(cap == {4'h9, 4'h1, 6'h0, mn[1]}, "R9 read allowed", 32'(cap), 32'({4'h9, 4'h1, 6'h0, mn[1]}));
        @(negedge clk); preset = 1'b1;
        repeat (3) @(negedge clk); preset = 1'b0;
        repeat (2) @(negedge clk);
        mw[0] = mn[0]; mw[1] = mn[1];
        check_wipers("R10 preset under protect");
        wp_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        mw[0] = 10'h200; mw[1] = 10'h200;
        mn[0] = 10'h200; mn[1] = 10'h200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write();
        t_deferred();
        t_store();
        t_busy_ignore();
        t_readback();
        t_unknown();
        t_daisy();
        t_protect();
        finish_run();
    end
endmodule